// File: doc/BRIEF.md
# In-Order Response Buffer

This block sits between the issue stage and the writeback stage of a load/store pipeline. Each request handed to memory first takes a slot in the buffer. The buffer returns a sequence ID for that request, and the ID rises by one per request, wrapping at the buffer depth. The memory system may answer in any order, so each answer carries its ID back. The answer is stored, and its slot is flagged complete.

In ordered mode only the slot holding the oldest outstanding ID may leave, and only after it is complete. Writeback therefore sees results in program order. In FIFO mode the same slots hold the data, but completed IDs are queued in the order they arrived and leave in that order.

The mode input may change only while nothing is outstanding. An answer whose ID is not outstanding, or whose slot is already complete, is discarded and flagged. Results leave one per cycle through a valid/ready handshake.

Top module: `inorder_rsp_buf`

## Requirements
- R1: After reset, alloc_ready is 1, out_valid is 0 and rsp_err is 0, and the first ID handed out is 0.
- R2: Each accepted allocation (alloc_valid and alloc_ready high at a clock edge) returns on alloc_id the previous ID plus one, modulo DEPTH.
- R3: alloc_ready is low while the next ID is still outstanding. In ordered mode that happens exactly when DEPTH IDs are outstanding. A request presented while alloc_ready is low consumes no ID. alloc_ready rises in the cycle after the retirement that frees the slot.
- R4: In ordered mode, results leave strictly in allocation order. Nothing leaves while the oldest outstanding ID has no response, even if younger IDs have completed.
- R5: A delivered result carries its ID on out_id and, on out_data, the data of the accepted response for that ID.
- R6: In FIFO mode (mode_ordered = 0), results leave in the order in which their responses were accepted, whatever their IDs.
- R7: A response whose ID is not outstanding, or whose slot is already complete, changes nothing and produces no output. It raises rsp_err for exactly the following cycle.
- R8: While out_valid is high and out_ready is low, out_valid, out_id and out_data hold. At most one result leaves per cycle.
- R9: A response that completes the deliverable slot drives out_valid high in the cycle after the response is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ordered | input | 1 | 1 = program-order delivery, 0 = arrival-order delivery |
| alloc_valid | input | 1 | Issue side requests a slot |
| alloc_ready | output | 1 | A slot is free for the next ID |
| alloc_id | output | $clog2(DEPTH) | ID given to the request accepted this cycle |
| rsp_valid | input | 1 | Memory response present |
| rsp_id | input | $clog2(DEPTH) | ID carried by the response |
| rsp_data | input | DW | Response payload |
| out_valid | output | 1 | A result is available for writeback |
| out_ready | input | 1 | Writeback accepts the result |
| out_id | output | $clog2(DEPTH) | ID of the result |
| out_data | output | DW | Payload of the result |
| rsp_err | output | 1 | Pulse: a response one cycle earlier was rejected |

## Verification
The hardest state to reach is a buffer in which every ID is outstanding and complete, the oldest has not left, and the ring has wrapped past ID DEPTH-1. Reaching it needs a complete fill with the output stalled. The bench first runs a short ordered sequence so the IDs are offset. It then allocates DEPTH more with out_ready held low and answers them youngest first. This exercises the wrap, the stalled hold, the refused extra allocation and a duplicate answer to a completed slot, all in one state.

// File: rtl/inorder_rsp_buf.sv
module inorder_rsp_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ordered,
  input  logic          alloc_valid,
  output logic          alloc_ready,
  output logic [IW-1:0] alloc_id,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_id,
  input  logic [DW-1:0] rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [IW-1:0] out_id,
  output logic [DW-1:0] out_data,
  output logic          rsp_err
);

  logic [DEPTH-1:0] busy, done;
  logic [DW-1:0]    data_q [DEPTH];
  logic [IW-1:0]    fq [DEPTH];
  logic [IW-1:0]    head, tail, frd, fwr;
  logic [IW:0]      fcnt;

  logic rsp_ok, alloc_fire, ret, push, pop;
  logic [IW-1:0] sel, tail_nxt;

  assign rsp_ok      = rsp_valid && busy[rsp_id] && !done[rsp_id];
  assign alloc_ready = !busy[tail];
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_id    = tail;
  assign tail_nxt    = tail + IW'(alloc_fire);

  assign sel       = mode_ordered ? head : fq[frd];
  assign out_valid = mode_ordered ? (busy[head] && done[head]) : (fcnt != '0);
  assign out_id    = sel;
  assign out_data  = data_q[sel];
  assign ret       = out_valid && out_ready;

  assign push = rsp_ok && !mode_ordered;
  assign pop  = ret && !mode_ordered;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
      done <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (alloc_fire && tail == IW'(i)) begin
          busy[i] <= 1'b1;
          done[i] <= 1'b0;
        end
        if (rsp_ok && rsp_id == IW'(i))
          done[i] <= 1'b1;
        if (ret && sel == IW'(i)) begin
          busy[i] <= 1'b0;
          done[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_ok)
      data_q[rsp_id] <= rsp_data;
    if (push)
      fq[fwr] <= rsp_id;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tail    <= '0;
      head    <= '0;
      frd     <= '0;
      fwr     <= '0;
      fcnt    <= '0;
      rsp_err <= 1'b0;
    end else begin
      tail    <= tail_nxt;
      head    <= mode_ordered ? head + IW'(ret) : tail_nxt;
      frd     <= frd + IW'(pop);
      fwr     <= fwr + IW'(push);
      fcnt    <= fcnt + (IW+1)'(push) - (IW+1)'(pop);
      rsp_err <= rsp_valid && !rsp_ok;
    end
  end

endmodule

module inorder_rsp_buf_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_ordered,
  input logic          alloc_valid,
  input logic          alloc_ready,
  input logic [IW-1:0] alloc_id,
  input logic          rsp_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic [IW-1:0] out_id,
  input logic [DW-1:0] out_data,
  input logic          rsp_err
);

  logic [IW-1:0] acnt, rcnt;
  logic [IW:0]   outst;
  logic a_f, r_f;

  assign a_f = alloc_valid && alloc_ready;
  assign r_f = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt  <= '0;
      rcnt  <= '0;
      outst <= '0;
    end else begin
      acnt  <= acnt + IW'(a_f);
      rcnt  <= rcnt + IW'(r_f);
      outst <= outst + (IW+1)'(a_f) - (IW+1)'(r_f);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= (IW+1)'(DEPTH));

  // R3
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst == (IW+1)'(DEPTH) |-> !alloc_ready);

  // R3
  ordered_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ordered && outst < (IW+1)'(DEPTH)) |-> alloc_ready);

  // R2
  alloc_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_f |-> alloc_id == acnt);

  // R4
  ordered_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ordered && out_valid) |-> out_id == rcnt);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_data)));

  // R7
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(rsp_valid));

  // R1
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst == '0 |-> !out_valid);

endmodule

bind inorder_rsp_buf inorder_rsp_buf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_ordered(mode_ordered),
  .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_id(alloc_id),
  .rsp_valid(rsp_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_id(out_id), .out_data(out_data), .rsp_err(rsp_err)
);

// File: tb/sim_inorder_rsp_buf.sv
module sim_inorder_rsp_buf;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int DW     = 32;
  localparam int IW     = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, mode_ordered = 1'b1;
  logic alloc_valid = 1'b0, rsp_valid = 1'b0, out_ready = 1'b1;
  logic [IW-1:0] rsp_id = '0;
  logic [DW-1:0] rsp_data = '0;
  logic alloc_ready, out_valid, rsp_err;
  logic [IW-1:0] alloc_id, out_id;
  logic [DW-1:0] out_data;

  int checks = 0, errs = 0, delivered = 0;
  logic [IW+DW-1:0] exp_q [$];

  always #(PERIOD/2) clk = ~clk;

  inorder_rsp_buf #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_ordered(mode_ordered),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_id(alloc_id),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_id(out_id),
    .out_data(out_data), .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dat(input int id);
    return DW'(32'hA500 + id * 17);
  endfunction

  task automatic do_alloc(input int exp_id, input bit exp_ok, input bit track);
    logic ok;
    logic [IW-1:0] id;
    @(posedge clk); #1;
    alloc_valid = 1'b1;
    ok = alloc_ready;
    id = alloc_id;
    chk(ok == exp_ok, "R3 alloc_ready", 64'(ok), 64'(exp_ok));
    if (exp_ok) begin
      chk(id == IW'(exp_id), "R2 alloc_id", 64'(id), 64'(exp_id));
      if (track) exp_q.push_back({id, dat(exp_id + 100)});
    end
    @(posedge clk); #1;
    alloc_valid = 1'b0;
  endtask

  // Data sent for ID i is dat(i+100); ordered mode pushes expectations at allocation time.
  task automatic do_rsp(input int id, input bit fifo_track);
    @(posedge clk); #1;
    rsp_valid = 1'b1;
    rsp_id    = IW'(id);
    rsp_data  = dat(id + 100);
    if (fifo_track) exp_q.push_back({IW'(id), dat(id + 100)});
    @(posedge clk); #1;
    rsp_valid = 1'b0;
  endtask

  task automatic bad_rsp(input int id);
    int d0;
    d0 = delivered;
    @(posedge clk); #1;
    rsp_valid = 1'b1;
    rsp_id    = IW'(id);
    rsp_data  = 32'hDEAD;
    @(posedge clk); #1;
    rsp_valid = 1'b0;
    chk(rsp_err == 1'b1, "R7 err raised", 64'(rsp_err), 64'd1);
    @(posedge clk); #1;
    chk(rsp_err == 1'b0, "R7 err one cycle", 64'(rsp_err), 64'd0);
    chk(delivered == d0, "R7 dropped", 64'(delivered), 64'(d0));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin : monitor
    logic [IW+DW-1:0] e;
    if (rst_n && out_valid && out_ready) begin
      delivered++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected output", 64'({out_id, out_data}), 64'd0);
      end else begin
        e = exp_q.pop_front();
        // R5 R6 order and payload
        chk({out_id, out_data} == e, "R5 R6 scoreboard", 64'({out_id, out_data}), 64'(e));
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 50000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1;
    // R1
    chk(alloc_ready == 1'b1, "R1 ready", 64'(alloc_ready), 64'd1);
    chk(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(rsp_err == 1'b0, "R1 rsp_err", 64'(rsp_err), 64'd0);
    chk(alloc_id == '0, "R1 first id", 64'(alloc_id), 64'd0);

    // Ordered, responses out of order
    for (int i = 0; i < 4; i++) do_alloc(i, 1'b1, 1'b1);
    do_rsp(2, 1'b0);
    do_rsp(1, 1'b0);
    do_rsp(3, 1'b0);
    idle(2);
    chk(out_valid == 1'b0, "R4 oldest pending", 64'(out_valid), 64'd0);
    do_rsp(0, 1'b0);
    chk(out_valid == 1'b1, "R9 next-cycle valid", 64'(out_valid), 64'd1);
    chk(out_id == '0, "R4 head id", 64'(out_id), 64'd0);
    idle(6);
    chk(delivered == 4, "R4 all delivered", 64'(delivered), 64'd4);

    // R7 rejected responses
    bad_rsp(0);
    bad_rsp(5);

    // Fill with stalled output, ids wrap
    out_ready = 1'b0;
    for (int i = 0; i < DEPTH; i++) do_alloc((4 + i) % DEPTH, 1'b1, 1'b1);
    do_alloc(4, 1'b0, 1'b0);
    chk(alloc_id == IW'(4), "R3 no id consumed", 64'(alloc_id), 64'd4);
    for (int i = DEPTH - 1; i >= 0; i--) do_rsp((4 + i) % DEPTH, 1'b0);
    chk(out_valid == 1'b1 && out_id == IW'(4), "R8 stalled head", 64'({out_valid, out_id}), 64'({1'b1, IW'(4)}));
    idle(3);
    chk(out_valid == 1'b1 && out_id == IW'(4) && out_data == dat(104), "R8 hold",
        64'(out_data), 64'(dat(104)));
    bad_rsp(5);
    chk(alloc_ready == 1'b0, "R3 full stall", 64'(alloc_ready), 64'd0);
    @(posedge clk); #1;
    out_ready = 1'b1;
    @(posedge clk); #1;
    chk(alloc_ready == 1'b1, "R3 ready after retire", 64'(alloc_ready), 64'd1);
    idle(12);
    chk(delivered == 12, "R4 drain count", 64'(delivered), 64'd12);

    // FIFO mode
    mode_ordered = 1'b0;
    for (int i = 0; i < 3; i++) do_alloc(4 + i, 1'b1, 1'b0);
    idle(2);
    chk(out_valid == 1'b0, "R6 nothing before response", 64'(out_valid), 64'd0);
    do_rsp(6, 1'b1);
    chk(out_valid == 1'b1 && out_id == IW'(6), "R9 fifo latency", 64'(out_id), 64'd6);
    do_rsp(4, 1'b1);
    do_rsp(5, 1'b1);
    idle(4);
    chk(delivered == 15, "R6 fifo count", 64'(delivered), 64'd15);
    chk(exp_q.size() == 0, "R6 scoreboard empty", 64'(exp_q.size()), 64'd0);
    bad_rsp(6);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule